// File: doc/BRIEF.md
# I2C Slave Register Access Port

This block lets an I2C master on a standard-mode bus (100 kbit/s) read and write a bank of configuration registers. The block samples SCL and SDA with the system clock and finds START, repeated START and STOP conditions on the sampled lines. It compares the 7-bit device address against strap inputs and acknowledges only when the address matches and lies in the usable range. It pulls SDA low, open-drain, for acknowledges and for the zero bits of read data.

Registers are reached through a stored pointer. In a write transaction the first byte after the address loads the pointer, and each later byte is written to the bank. A working address starts from the pointer and steps by one after every data byte. The stored pointer does not move, so the next transaction starts again where the last pointer byte placed it. A read can follow directly on an address with the read bit set, which reads from the stored pointer. A read can also follow a pointer-only write and a repeated START, which reads from the new pointer. The register bank sits outside the block, behind a plain parallel port: an address, a one-cycle write strobe with write data, and combinational read data.

Top module: `i2c_reg_port`

## Requirements
- R1: After reset SDA is released (`sdaOe` = 0) and `regWrEn` is 0.
- R2: The first byte after a START carries the 7-bit address MSB first, with the read/write flag in bit 0 (1 = read). When the address equals `devId`, the block pulls SDA low for the ninth clock.
- R3: Addresses 0 to 7 and 120 to 127 are never acknowledged, even when `devId` holds them. Addresses 8 and 119 are acknowledged.
- R4: A byte with any other address is not acknowledged. The block then ignores the bus until the next START or STOP and makes no register write.
- R5: In a write transaction the first byte after the address is acknowledged and loads the pointer. It causes no register write.
- R6: Each later write byte k (k = 0, 1, ...) is acknowledged and produces exactly one single-cycle `regWrEn` with `regAddr` = pointer + k (modulo 2^REG_AW) and `regWrData` = the byte.
- R7: The stored pointer is not changed by the stepping of the working address. A later read starts again at the last pointer written.
- R8: A read that starts directly after the address returns bank[pointer], bank[pointer+1], ... MSB first, with the next byte sent after each master ACK.
- R9: A write of the pointer byte alone, then a repeated START and the address with the read flag, returns data starting at the new pointer.
- R10: After the master NACKs a read byte, SDA stays released, so any further clocked byte reads as 0xFF until the next START.
- R11: A START or STOP aborts any transfer in progress. A repeated START during a write begins a fresh transaction, and a STOP releases SDA and returns to idle.
- R12: `sdaOe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | I2C clock line as seen at the pad |
| sdaIn | input | 1 | I2C data line as seen at the pad |
| devId | input | 7 | Strapped device address, bit 0 is the LSB |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regAddr | output | REG_AW | Register bank address (working address) |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Register write data |
| regRdData | input | 8 | Register read data for `regAddr` |

## Verification
Two situations are hard to reach from the ports. One is a repeated START that arrives in the middle of a write after a pointer has already been loaded. The other is the master clocking extra bytes after it NACKs a read. The bench's master tasks build each bus condition bit by bit, so a transaction can be cut with a repeated START at any byte boundary. After a NACK the bench clocks another byte and checks that the line reads all ones. Writes to the boundary addresses 7, 8, 119 and 120 are reached by changing the straps between transactions.

// File: rtl/i2c_port_pkg.sv
package i2c_port_pkg;
  localparam int BYTE_W = 8;
  localparam int ADR_W  = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_SKIP
  } ctrlState_e;

  typedef struct packed {
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic setPtr;
    logic workFromPtr;
    logic workInc;
    logic writeReg;
  } dpStrobe_t;
endpackage

// File: rtl/i2c_port_dp.sv
module i2c_port_dp
  import i2c_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         stb,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              sclLevel,
  output logic              sdaLevel,
  output logic              sclRise,
  output logic              sclFall,
  output logic              busStart,
  output logic              busStop,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic [REG_AW-1:0] regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclQ, sdaQ;
  logic [BYTE_W-1:0] rxShift, txShift;
  logic [REG_AW-1:0] ptrQ, workAddr;

  // two-stage (or deeper) synchroniser followed by one history stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclPipe[SYNC_STAGES-1];
      sdaQ    <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclLevel = sclPipe[SYNC_STAGES-1];
  assign sdaLevel = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclLevel & ~sclQ;
  assign sclFall  = ~sclLevel & sclQ;
  assign busStart = sclLevel & sclQ & sdaQ & ~sdaLevel;
  assign busStop  = sclLevel & sclQ & ~sdaQ & sdaLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '1;
      ptrQ      <= '0;
      workAddr  <= '0;
      regWrEn   <= 1'b0;
      regWrData <= '0;
    end else begin
      regWrEn <= stb.writeReg;
      if (stb.writeReg) regWrData <= rxShift;
      if (stb.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaLevel};
      if (stb.loadTx) txShift <= regRdData;
      else if (stb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
      if (stb.setPtr) begin
        ptrQ     <= rxShift[REG_AW-1:0];
        workAddr <= rxShift[REG_AW-1:0];
      end else if (stb.workFromPtr) begin
        workAddr <= ptrQ;
      end else if (stb.workInc) begin
        workAddr <= workAddr + 1'b1;
      end
    end
  end

  assign rxByte  = rxShift;
  assign txMsb   = txShift[BYTE_W-1];
  assign regAddr = workAddr;
endmodule

// File: rtl/i2c_port_ctrl.sv
module i2c_port_ctrl
  import i2c_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              busStart,
  input  logic              busStop,
  input  logic              sdaLevel,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  input  logic [ADR_W-1:0]  devId,
  output dpStrobe_t         stb,
  output logic              sdaOe
);
  ctrlState_e st, stNext;
  logic [3:0] bitCnt, cntNext;
  logic isRead, rdNext;
  logic mAckQ, ackNext;
  logic addrHit;
  logic [ADR_W-1:0] rxAddr;

  assign rxAddr  = rxByte[BYTE_W-1:1];
  // reserved groups: top four address bits all zero or all one
  assign addrHit = (rxAddr == devId) && (rxAddr[ADR_W-1:3] != 4'h0)
                   && (rxAddr[ADR_W-1:3] != 4'hF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      bitCnt <= '0;
      isRead <= 1'b0;
      mAckQ  <= 1'b0;
    end else begin
      st     <= stNext;
      bitCnt <= cntNext;
      isRead <= rdNext;
      mAckQ  <= ackNext;
    end
  end

  always_comb begin
    stNext  = st;
    cntNext = bitCnt;
    rdNext  = isRead;
    ackNext = mAckQ;
    stb     = '0;
    if (busStop) begin
      stNext = ST_IDLE;
    end else if (busStart) begin
      stNext  = ST_ADDR;
      cntNext = '0;
    end else begin
      case (st)
        ST_ADDR, ST_PTR, ST_WR: begin
          if (sclRise) begin
            stb.shiftIn = 1'b1;
            cntNext     = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            cntNext = '0;
            if (st == ST_ADDR) begin
              if (addrHit) begin
                stNext          = ST_ADDR_ACK;
                rdNext          = rxByte[0];
                stb.workFromPtr = rxByte[0];
              end else begin
                stNext = ST_SKIP;
              end
            end else if (st == ST_PTR) begin
              stb.setPtr = 1'b1;
              stNext     = ST_PTR_ACK;
            end else begin
              stb.writeReg = 1'b1;
              stNext       = ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            if (isRead) begin
              stb.loadTx = 1'b1;
              stNext     = ST_RD;
            end else begin
              stNext = ST_PTR;
            end
          end
        end
        ST_PTR_ACK: if (sclFall) stNext = ST_WR;
        ST_WR_ACK: begin
          if (sclFall) begin
            stb.workInc = 1'b1;
            stNext      = ST_WR;
          end
        end
        ST_RD: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stNext  = ST_RD_ACK;
              cntNext = '0;
            end else begin
              stb.shiftTx = 1'b1;
              cntNext     = bitCnt + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            ackNext     = ~sdaLevel;
            stb.workInc = ~sdaLevel;
          end else if (sclFall) begin
            if (mAckQ) begin
              stb.loadTx = 1'b1;
              stNext     = ST_RD;
            end else begin
              stNext = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = (st == ST_ADDR_ACK) || (st == ST_PTR_ACK) || (st == ST_WR_ACK)
                 || ((st == ST_RD) && !txMsb);
endmodule

// File: rtl/i2c_reg_port.sv
module i2c_reg_port
  import i2c_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [6:0]        devId,
  output logic              sdaOe,
  output logic [REG_AW-1:0] regAddr,
  output logic              regWrEn,
  output logic [7:0]        regWrData,
  input  logic [7:0]        regRdData
);
  dpStrobe_t stb;
  logic sclLevel, sdaLevel, sclRise, sclFall, busStart, busStop, txMsb;
  logic [BYTE_W-1:0] rxByte;

  i2c_port_dp #(.SYNC_STAGES(SYNC_STAGES), .REG_AW(REG_AW)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .regRdData(regRdData), .sclLevel(sclLevel), .sdaLevel(sdaLevel),
    .sclRise(sclRise), .sclFall(sclFall), .busStart(busStart),
    .busStop(busStop), .rxByte(rxByte), .txMsb(txMsb), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData)
  );

  i2c_port_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .busStart(busStart), .busStop(busStop), .sdaLevel(sdaLevel),
    .rxByte(rxByte), .txMsb(txMsb), .devId(devId), .stb(stb), .sdaOe(sdaOe)
  );
endmodule

// File: rtl/i2c_reg_port_chk.sv
module i2c_reg_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclS,
  input logic       busStop,
  input logic       sdaOe,
  input logic       regWrEn,
  input logic [6:0] devId
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS); // R12
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    busStop |=> !sdaOe); // R11
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn); // R6
  AST_WR_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !sclS); // R6
  AST_WR_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (devId[6:3] != 4'h0) && (devId[6:3] != 4'hF)); // R3
endmodule

bind i2c_reg_port i2c_reg_port_chk u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclLevel), .busStop(busStop),
  .sdaOe(sdaOe), .regWrEn(regWrEn), .devId(devId)
);

// File: tb/i2c_reg_port_bench.sv
module i2c_reg_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic [6:0] devId = 7'h2A;
  logic sdaOe, regWrEn, sdaLine;
  logic [7:0] regAddr, regWrData, regRdData;
  logic [7:0] bank [256];
  logic [7:0] refMem [256];
  logic [15:0] expWr [$];
  int total = 0;
  int bad = 0;
  bit done = 0;
  logic prevOe = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign sdaLine = mSda & ~sdaOe;

  i2c_reg_port u_i2c_reg_port (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .devId(devId),
    .sdaOe(sdaOe), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  // external register bank
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) bank[i] <= 8'(i * 7 + 3);
    end else if (regWrEn) begin
      bank[regAddr] <= regWrData;
    end
  end
  assign regRdData = bank[regAddr];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference write stream and SDA rule
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (regWrEn) begin
        if (expWr.size() == 0) begin
          check(0, "R4 R6 unexpected write", {regAddr, regWrData}, 0);
        end else begin
          logic [15:0] e;
          e = expWr.pop_front();
          check({regAddr, regWrData} == e, "R6 write addr/data", {regAddr, regWrData}, e);
        end
      end
      if (sdaOe !== prevOe) check(scl == 1'b0, "R12 sdaOe change with SCL low", scl, 0);
      prevOe = sdaOe;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; tick(Q);
    scl = 1'b1; tick(2 * Q);
    mSda = 1'b0; tick(2 * Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(Q);
    scl = 1'b1; tick(2 * Q);
    mSda = 1'b1; tick(2 * Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; tick(Q);
      scl = 1'b1; tick(2 * Q);
      scl = 1'b0; tick(Q);
    end
    mSda = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    acked = (sdaLine == 1'b0);
    tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b = {b[6:0], sdaLine};
      tick(Q);
      scl = 1'b0; tick(Q);
    end
    mSda = ackIt ? 1'b0 : 1'b1; tick(Q);
    scl = 1'b1; tick(2 * Q);
    scl = 1'b0; tick(Q);
    mSda = 1'b1;
  endtask

  task automatic expectWrite(input logic [7:0] a, input logic [7:0] d);
    expWr.push_back({a, d});
    refMem[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [7:0] rd;
    for (int i = 0; i < 256; i++) refMem[i] = 8'(i * 7 + 3);
    tick(5);
    check(sdaOe == 1'b0, "R1 SDA released in reset", sdaOe, 0);
    rstN = 1'b1;
    tick(5);
    check(sdaOe == 1'b0 && regWrEn == 1'b0, "R1 idle after reset", {sdaOe, regWrEn}, 0);

    // write pointer 0x10 and three data bytes
    busStart();
    sendByte(8'h54, ak); check(ak, "R2 address ack", ak, 1);
    sendByte(8'h10, ak); check(ak, "R5 pointer ack", ak, 1);
    check(expWr.size() == 0, "R5 no write for pointer", expWr.size(), 0);
    expectWrite(8'h10, 8'hA1); sendByte(8'hA1, ak); check(ak, "R6 data ack 0", ak, 1);
    expectWrite(8'h11, 8'hB2); sendByte(8'hB2, ak); check(ak, "R6 data ack 1", ak, 1);
    expectWrite(8'h12, 8'hC3); sendByte(8'hC3, ak); check(ak, "R6 data ack 2", ak, 1);
    busStop();
    check(expWr.size() == 0, "R6 all writes seen", expWr.size(), 0);
    check(sdaOe == 1'b0, "R11 released after stop", sdaOe, 0);

    // preset-pointer read, three bytes
    busStart();
    sendByte(8'h55, ak); check(ak, "R2 read address ack", ak, 1);
    recvByte(1, rd); check(rd == refMem[8'h10], "R8 read byte 0", rd, refMem[8'h10]);
    recvByte(1, rd); check(rd == refMem[8'h11], "R8 read byte 1", rd, refMem[8'h11]);
    recvByte(0, rd); check(rd == refMem[8'h12], "R8 read byte 2", rd, refMem[8'h12]);
    busStop();

    // pointer unchanged by the increments
    busStart();
    sendByte(8'h55, ak);
    recvByte(0, rd); check(rd == refMem[8'h10], "R7 pointer kept", rd, refMem[8'h10]);
    busStop();

    // new pointer, repeated start, read; then clock past NACK
    busStart();
    sendByte(8'h54, ak);
    sendByte(8'h12, ak); check(ak, "R9 pointer ack", ak, 1);
    busStart();
    sendByte(8'h55, ak); check(ak, "R9 read address ack", ak, 1);
    recvByte(1, rd); check(rd == refMem[8'h12], "R9 read new pointer", rd, refMem[8'h12]);
    recvByte(0, rd); check(rd == refMem[8'h13], "R9 read next", rd, refMem[8'h13]);
    recvByte(1, rd); check(rd == 8'hFF, "R10 released after NACK", rd, 8'hFF);
    busStop();

    // repeated start aborts a write and starts a fresh one
    busStart();
    sendByte(8'h54, ak);
    sendByte(8'h40, ak);
    busStart();
    sendByte(8'h54, ak); check(ak, "R11 address after restart", ak, 1);
    sendByte(8'h50, ak);
    expectWrite(8'h50, 8'h99); sendByte(8'h99, ak);
    busStop();
    busStart();
    sendByte(8'h55, ak);
    recvByte(0, rd); check(rd == 8'h99, "R11 pointer from fresh write", rd, 8'h99);
    busStop();

    // wrong address: no ack, no writes
    busStart();
    sendByte(8'h56, ak); check(!ak, "R4 mismatch not acked", ak, 0);
    sendByte(8'h33, ak); check(!ak, "R4 following byte ignored", ak, 0);
    sendByte(8'h44, ak);
    busStop();

    // reserved and boundary addresses
    devId = 7'h05;
    busStart(); sendByte(8'h0A, ak); check(!ak, "R3 address 5 reserved", ak, 0);
    sendByte(8'h77, ak); busStop();
    devId = 7'h07;
    busStart(); sendByte(8'h0E, ak); check(!ak, "R3 address 7 reserved", ak, 0); busStop();
    devId = 7'h78;
    busStart(); sendByte(8'hF0, ak); check(!ak, "R3 address 120 reserved", ak, 0); busStop();
    devId = 7'h7A;
    busStart(); sendByte(8'hF4, ak); check(!ak, "R3 address 122 reserved", ak, 0); busStop();
    devId = 7'h08;
    busStart(); sendByte(8'h10, ak); check(ak, "R3 address 8 valid", ak, 1);
    sendByte(8'h20, ak);
    expectWrite(8'h20, 8'h5A); sendByte(8'h5A, ak);
    busStop();
    devId = 7'h77;
    busStart(); sendByte(8'hEF, ak); check(ak, "R3 address 119 valid", ak, 1);
    recvByte(0, rd); check(rd == 8'h5A, "R3 R8 read at 119", rd, 8'h5A);
    busStop();
    tick(20);
    check(expWr.size() == 0, "R4 R6 write stream complete", expWr.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule